// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes written into a holding register into asynchronous serial frames. Each frame has a low start bit, then the data bits least significant first, then a high stop bit. A length-mode input selects 8 or 9 data bits. In 9-bit mode the extra bit comes from a separate input, which is sampled when the byte moves into the shift register. There is no internal baud generator. A one-cycle tick input marks every bit boundary, and the line changes only on those ticks.

Software treats it like any byte-wide transmitter. It writes a byte whenever the empty flag is high. The flag is also routed to an interrupt request, which is gated by an interrupt-enable input. A held byte waits until the character in flight has finished, and then starts on the very next tick. A send-break input replaces normal traffic with characters that are entirely low. These characters run back to back for as long as the input is held. Once the input is released, the current break character completes and then a single high bit goes out, so a receiver can find the next start edge. Dropping the module enable hands the pin back through an output-enable signal and abandons any character in flight.

Top module: `uart_brk_tx`

## Requirements
- R1: During and straight after reset the line is high, the empty flag is high and no interrupt is requested.
- R2: The first tick after a byte is taken drives the start bit (0). The last bit of every frame is a stop bit (1), and every bit lasts exactly one tick interval.
- R3: The data bits follow the start bit, least significant first, one per tick. In 8-bit mode a frame is 10 bits long.
- R4: When `len9` is high at the moment of loading, the value of `tx_bit8` at that same moment is sent after the eight data bits. The frame is then 11 bits long.
- R5: On a tick where nothing is being sent and nothing is waiting, the line stays high.
- R6: If `send_break` is high on a tick at a character boundary, a break character is sent instead of any waiting byte. A break character is all zeros and lasts 10 ticks, or 11 ticks when `len9` is high.
- R7: While `send_break` stays high, break characters follow one another with no high bit in between.
- R8: After `send_break` falls, the break character in progress completes. The next boundary tick then sends exactly one high bit before any start bit.
- R9: A write clears the empty flag. Moving the held byte into the shift register sets the flag, unless a write arrives in the same cycle. A held byte starts on the first boundary tick after the character in progress.
- R10: `tx_irq` is high exactly when `tx_int_en` and the empty flag are both high.
- R11: While `tx_en` is low, `tx_oe` is low and the line is high from the next clock on. Ticks are ignored and any character in flight is dropped. The held byte and the empty flag are kept.
- R12: While enabled, the line changes only on a clock edge at which `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Module enable; low releases the pin |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| len9 | input | 1 | 1 selects 9 data bits per character |
| tx_bit8 | input | 1 | Ninth data bit, sampled at load |
| send_break | input | 1 | Hold high to send break characters |
| tx_int_en | input | 1 | Interrupt enable for the empty flag |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| tx_line | output | 1 | Serial output line |
| tx_oe | output | 1 | Pin drive enable |
| tx_empty | output | 1 | Holding register can accept a byte |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The line, the empty flag and any load decision all come from registers. They are therefore due one clock after the edge that samples the tick, write or enable, and the bench reads them at the falling edge that follows that edge. `tx_irq` and `tx_oe` are combinational, so they are compared in the same half cycle as the inputs that feed them. Expected values come from a queue of expected bits that the bench refills only at character boundaries. Every tick that produces a bit, and every cycle without a tick, is compared at that single sampling point.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;
  // What the shift engine does at a character boundary tick.
  typedef enum logic [2:0] {
    SLOT_NONE  = 3'd0, // no boundary decision this cycle
    SLOT_IDLE  = 3'd1, // nothing to send, line high
    SLOT_FRAME = 3'd2, // held byte moves into the shifter
    SLOT_BREAK = 3'd3, // all-zero break character
    SLOT_GUARD = 3'd4  // single high bit after a break
  } slot_e;
endpackage

// File: rtl/uart_brk_tx_hold.sv
module uart_brk_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else begin
      if (wr_valid) hold_data <= wr_data;
      // a write landing with a take refills the register
      if (wr_valid)  hold_full <= 1'b1;
      else if (take) hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_brk_tx_shift.sv
module uart_brk_tx_shift
  import uart_brk_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              baud_tick,
  input  logic              len9,
  input  logic              bit8,
  input  logic              break_req,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              tx_line,
  output logic              take,
  output logic              load_break,
  output logic              guard_pend,
  output logic              eng_idle
);
  localparam int unsigned FW = DATA_W + 3;
  localparam int unsigned CW = $clog2(FW + 1);

  // Frame image, bit 0 leaves first: start, data, optional ninth bit, stop.
  function automatic logic [FW-1:0] frame_word(input logic [DATA_W-1:0] d,
                                               input logic b8, input logic l9);
    if (l9) frame_word = {1'b1, b8, d, 1'b0};
    else    frame_word = {1'b0, 1'b1, d, 1'b0};
  endfunction

  // Character length in bit times, for frames and break characters alike.
  function automatic logic [CW-1:0] char_bits(input logic l9);
    char_bits = l9 ? CW'(DATA_W + 3) : CW'(DATA_W + 2);
  endfunction

  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          guard;
  logic          step;
  slot_e         slot;
  logic [FW-1:0] fword;

  assign step     = enable && baud_tick;
  assign eng_idle = (cnt == '0);
  assign fword    = frame_word(hold_data, bit8, len9);

  always_comb begin
    if (!(step && eng_idle)) slot = SLOT_NONE;
    else if (break_req)      slot = SLOT_BREAK;
    else if (guard)          slot = SLOT_GUARD;
    else if (hold_full)      slot = SLOT_FRAME;
    else                     slot = SLOT_IDLE;
  end

  assign take       = (slot == SLOT_FRAME);
  assign load_break = (slot == SLOT_BREAK);
  assign guard_pend = guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      guard   <= 1'b0;
      tx_line <= 1'b1;
    end else if (!enable) begin
      cnt     <= '0;
      guard   <= 1'b0;
      tx_line <= 1'b1;
    end else if (step) begin
      if (!eng_idle) begin
        tx_line <= sh[0];
        sh      <= sh >> 1;
        cnt     <= cnt - CW'(1);
      end else begin
        case (slot)
          SLOT_FRAME: begin
            tx_line <= fword[0];
            sh      <= fword >> 1;
            cnt     <= char_bits(len9) - CW'(1);
          end
          SLOT_BREAK: begin
            tx_line <= 1'b0;
            sh      <= '0;
            cnt     <= char_bits(len9) - CW'(1);
            guard   <= 1'b1;
          end
          SLOT_GUARD: begin
            tx_line <= 1'b1;
            guard   <= 1'b0;
          end
          default: tx_line <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              len9,
  input  logic              tx_bit8,
  input  logic              send_break,
  input  logic              tx_int_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_line,
  output logic              tx_oe,
  output logic              tx_empty,
  output logic              tx_irq
);
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              take;
  logic              load_break;
  logic              guard_pend;
  logic              eng_idle;

  uart_brk_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  uart_brk_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (tx_en),
    .baud_tick  (baud_tick),
    .len9       (len9),
    .bit8       (tx_bit8),
    .break_req  (send_break),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .tx_line    (tx_line),
    .take       (take),
    .load_break (load_break),
    .guard_pend (guard_pend),
    .eng_idle   (eng_idle)
  );

  assign tx_oe    = tx_en;
  assign tx_empty = !hold_full;
  assign tx_irq   = tx_int_en && tx_empty;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic baud_tick,
  input logic send_break,
  input logic tx_int_en,
  input logic wr_valid,
  input logic tx_line,
  input logic tx_empty,
  input logic tx_irq,
  input logic take,
  input logic load_break,
  input logic guard_pend,
  input logic eng_idle
);
  a_r12_line_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !baud_tick) |=> $stable(tx_line));

  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !tx_line);

  a_r6_break_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_break |=> !tx_line);

  a_r8_guard_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && baud_tick && eng_idle && guard_pend && !send_break) |=> tx_line);

  a_r9_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !tx_empty);

  a_r9_take_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_valid) |=> tx_empty);

  a_r9_take_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !tx_empty);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_int_en |-> !tx_irq);

  a_r11_disabled_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_line);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .baud_tick  (baud_tick),
  .send_break (send_break),
  .tx_int_en  (tx_int_en),
  .wr_valid   (wr_valid),
  .tx_line    (tx_line),
  .tx_empty   (tx_empty),
  .tx_irq     (tx_irq),
  .take       (take),
  .load_break (load_break),
  .guard_pend (guard_pend),
  .eng_idle   (eng_idle)
);

// File: tb/test_uart_brk_tx.sv
module test_uart_brk_tx;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1, baud_tick = 1'b0, len9 = 1'b0, tx_bit8 = 1'b0;
  logic send_break = 1'b0, tx_int_en = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic tx_line, tx_oe, tx_empty, tx_irq;

  always #2.5 clk = ~clk;

  uart_brk_tx #(.DATA_W(DW)) i_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
    .len9(len9), .tx_bit8(tx_bit8), .send_break(send_break),
    .tx_int_en(tx_int_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_line(tx_line), .tx_oe(tx_oe), .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // next-cycle stimulus
  bit n_w = 0, n_tk = 0, n_brk = 0, n_l9 = 0, n_b8 = 0, n_en = 1, n_ti = 0;
  logic [DW-1:0] n_d = '0;

  // reference model
  bit    qb[$];
  string qt[$];
  bit    m_pend = 0, m_guard = 0, m_prev_brk = 0;
  logic [DW-1:0] m_data = '0;
  bit    e_line = 1;
  string e_tag = "R1 idle after reset";

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void push_frame(input logic [DW-1:0] d, input bit l9, input bit b8);
    qb.push_back(1'b0); qt.push_back("R2 start bit");
    for (int i = 0; i < DW; i++) begin
      qb.push_back(d[i]); qt.push_back("R3 data bit");
    end
    if (l9) begin qb.push_back(b8); qt.push_back("R4 ninth bit"); end
    qb.push_back(1'b1); qt.push_back("R2 stop bit");
  endfunction

  task automatic step();
    @(negedge clk);
    chk(e_tag, tx_line, e_line);
    chk("R9 empty flag", tx_empty, !m_pend);
    chk("R10 irq", tx_irq, tx_int_en & !m_pend);
    chk("R11 output enable", tx_oe, tx_en);
    wr_valid = n_w; wr_data = n_d; tx_bit8 = n_b8; baud_tick = n_tk;
    send_break = n_brk; len9 = n_l9; tx_en = n_en; tx_int_en = n_ti;
    if (!n_en) begin
      qb.delete(); qt.delete();
      m_guard = 0; m_prev_brk = 0;
      e_line = 1; e_tag = "R11 disabled line";
    end else if (n_tk) begin
      if (qb.size() == 0) begin
        if (n_brk) begin
          for (int i = 0; i < (n_l9 ? DW + 3 : DW + 2); i++) begin
            qb.push_back(1'b0);
            qt.push_back(m_prev_brk ? "R7 back-to-back break" : "R6 break bit");
          end
          m_guard = 1; m_prev_brk = 1;
        end else if (m_guard) begin
          qb.push_back(1'b1); qt.push_back("R8 guard bit");
          m_guard = 0; m_prev_brk = 0;
        end else if (m_pend) begin
          push_frame(m_data, n_l9, n_b8);
          m_pend = 0; m_prev_brk = 0;
        end else m_prev_brk = 0;
      end
      if (qb.size() != 0) begin
        e_line = qb.pop_front(); e_tag = qt.pop_front();
      end else begin
        e_line = 1; e_tag = "R5 idle line";
      end
    end else e_tag = "R12 hold between ticks";
    if (n_w) begin m_pend = 1; m_data = n_d; end
  endtask

  task automatic write_byte(input logic [DW-1:0] d);
    n_w = 1; n_d = d; step(); n_w = 0;
  endtask

  task automatic ticks(input int k, input int gap);
    for (int i = 0; i < k; i++) begin
      n_tk = 1; step(); n_tk = 0;
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 line in reset", tx_line, 1'b1);
      chk("R1 empty in reset", tx_empty, 1'b1);
      chk("R1 irq in reset", tx_irq, 1'b0);
    end
    rst_n = 1'b1;
    step(); step();
    ticks(3, 1);                       // R5 idle
    n_ti = 1; step();                  // R10 irq raised by empty
    write_byte(8'hA5); step();
    ticks(13, 2);                      // R2 R3 frame
    n_l9 = 1; n_b8 = 1; write_byte(8'h3C);
    ticks(13, 1);                      // R4 ninth bit 1
    n_b8 = 0; write_byte(8'hC3);
    ticks(13, 0);                      // R4 ninth bit 0
    n_l9 = 0;
    write_byte(8'h81); ticks(1, 0);
    write_byte(8'h7E); ticks(22, 1);   // R9 back-to-back frames
    write_byte(8'h55); n_brk = 1;
    ticks(25, 1);                      // R6 R7 break wins over byte
    n_brk = 0; ticks(15, 1);           // R8 guard then byte
    n_l9 = 1; n_brk = 1; ticks(30, 0); // R6 11-bit breaks
    n_brk = 0; n_l9 = 0; ticks(6, 0);
    write_byte(8'hF0); ticks(4, 1);
    n_en = 0; ticks(3, 1);             // R11 abandon frame
    write_byte(8'h0F); n_en = 1;
    ticks(14, 1);
    for (int c = 0; c < 20000; c++) begin
      n_tk = ($urandom % 3) == 0;
      n_w  = ($urandom % 40) == 0;
      n_d  = DW'($urandom);
      n_b8 = $urandom % 2;
      if ($urandom % 200 == 0) n_brk = !n_brk;
      if ($urandom % 500 == 0) n_l9 = !n_l9;
      if ($urandom % 50 == 0)  n_ti = !n_ti;
      if (n_en ? ($urandom % 3000 == 0) : ($urandom % 20 == 0)) n_en = !n_en;
      step();
    end
    n_w = 0; n_tk = 0; step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule